// File: doc/BRIEF.md
# Steered Watchdog Timer

This block supervises a processor by expecting periodic activity on a service input. It counts ticks of a slow time base, where one tick stands for 1/16 s. The count is restarted by any change of level on the service input or by a write to the configuration register. If the count reaches the programmed limit first, the block records the event in a sticky flag. It then takes one of two actions. It can raise an interrupt that stays up until software reads the flag. Or it can emit a fixed-length reset pulse and wipe its own configuration, which leaves the watchdog disarmed until software sets it up again.

The limit is a 5-bit multiplier times a resolution chosen by a 2-bit code. This covers 62.5 ms up to 124 s in 1/16 s to 4 s steps. A multiplier of zero switches supervision off. Register access is reduced to a write strobe with data, a read-back bus and a strobe that marks a read of the flags.

Top module: `wdog_steer`

## Requirements
- R1: The configuration byte has three fields: bit 7 selects the action, bits 6..2 hold the multiplier M, and bits 1..0 hold the resolution code. Code 0 means 1 tick, code 1 means 4 ticks, code 2 means 16 ticks and code 3 means 64 ticks. Expiry occurs on the M×resolution-th tick after the last restart, and never earlier.
- R2: When bit 7 is 1, expiry drives the reset output high for exactly RST_PULSE_CYC cycles, starting in the cycle after the final tick. The same expiry clears the configuration byte to 0, so no later expiry occurs, and the interrupt output stays low.
- R3: When bit 7 is 0, expiry raises the interrupt output together with the flag. The interrupt stays high until a flag-read strobe, which clears both the interrupt and the flag.
- R4: With M equal to 0, no number of ticks causes an expiry.
- R5: Either a rising or a falling edge on the service input restarts the count from zero. A service edge in the same cycle as what would have been the final tick prevents that expiry.
- R6: A write to the configuration byte restarts the count from zero.
- R7: Every expiry sets the flag. An expiry that coincides with a flag-read strobe leaves the flag set.
- R8: After reset, the flag, interrupt and reset outputs are low and the configuration byte reads 0.
- R9: The configuration byte reads back the last value written, unless an expiry in reset mode has cleared it since then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per 1/16 s time-base step |
| wd_kick_i | input | 1 | Service input; any edge restarts the count |
| cfg_wr_i | input | 1 | Write strobe for the configuration byte |
| cfg_wdata_i | input | 8 | Configuration data {action, multiplier, resolution} |
| cfg_rdata_o | output | 8 | Current configuration byte |
| flag_rd_i | input | 1 | Flags-register read strobe; clears flag and interrupt |
| wd_flag_o | output | 1 | Sticky expiry flag |
| wd_irq_o | output | 1 | Interrupt output (interrupt mode) |
| wd_rst_o | output | 1 | Fixed-length reset pulse (reset mode) |

## Verification
The assertions assume that every input is synchronous to clk and that tick_i is high for single cycles only. They also assume that the service input changes at most once per cycle, so every change counts as exactly one edge. The stimulus changes inputs only on falling clock edges and gives each tick a low cycle after it. It keeps the service input low across reset, so no spurious restart appears when reset is released. Coincidences are created on purpose, in one chosen cycle each: a service edge landing on the final tick, and a flag read landing on the expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    RES_SIXTEENTH = 2'b00,
    RES_QUARTER   = 2'b01,
    RES_ONE       = 2'b10,
    RES_FOUR      = 2'b11
  } wd_res_e;

  // ticks per resolution step: each code multiplies by four
  function automatic int unsigned res_ticks(input int unsigned code);
    return 32'd1 << (2 * code);
  endfunction

  function automatic int unsigned timeout_ticks(input int unsigned mult,
                                                input int unsigned code);
    return mult * res_ticks(code);
  endfunction

endpackage

// File: rtl/wdog_kick_edge.sv
module wdog_kick_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic edge_o
);
  logic kick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kick_q <= 1'b0;
    else        kick_q <= kick_i;
  end

  assign edge_o = kick_i ^ kick_q;
endmodule

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_i,
  input  logic [MULT_W+RES_W:0]       wdata_i,
  input  logic                        clr_i,
  output logic [MULT_W+RES_W:0]       rdata_o,
  output logic                        steer_o,
  output logic [MULT_W-1:0]           mult_o,
  output logic [RES_W-1:0]            res_o
);
  localparam int REG_W = 1 + MULT_W + RES_W;

  logic [REG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_i)  cfg_q <= wdata_i;
    else if (clr_i) cfg_q <= '0;
  end

  assign rdata_o = cfg_q;
  assign steer_o = cfg_q[REG_W-1];
  assign mult_o  = cfg_q[RES_W +: MULT_W];
  assign res_o   = cfg_q[RES_W-1:0];

  // R9: a write is visible on the read-back bus in the next cycle
  a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> rdata_o == $past(wdata_i));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [RES_W-1:0]  res_i,
  output logic              expire_o
);
  localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

  logic [CNT_W-1:0] cnt_q, limit;
  logic             armed;

  assign armed    = |mult_i;
  assign limit    = CNT_W'(timeout_ticks(32'(mult_i), 32'(res_i)));
  assign expire_o = armed && tick_i && !restart_i
                    && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (restart_i || !armed) cnt_q <= '0;
    else if (expire_o)           cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + CNT_W'(1);
  end

  // R1: while armed the tick count never reaches the limit
  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> cnt_q < limit);
endmodule

// File: rtl/wdog_outputs.sv
module wdog_outputs #(
  parameter int RST_PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic steer_i,
  input  logic flag_rd_i,
  output logic flag_o,
  output logic irq_o,
  output logic rst_o
);
  localparam int PW = $clog2(RST_PULSE_CYC + 1);

  logic [PW-1:0] pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o  <= 1'b0;
      irq_o   <= 1'b0;
      pulse_q <= '0;
    end else begin
      if (expire_i)       flag_o <= 1'b1;
      else if (flag_rd_i) flag_o <= 1'b0;

      if (expire_i && !steer_i) irq_o <= 1'b1;
      else if (flag_rd_i)       irq_o <= 1'b0;

      if (expire_i && steer_i) pulse_q <= PW'(RST_PULSE_CYC);
      else if (pulse_q != '0)  pulse_q <= pulse_q - PW'(1);
    end
  end

  assign rst_o = pulse_q != '0;

  // R3: the interrupt never stands without the flag
  a_r3_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o);
  // R7: a read without a coinciding expiry clears the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd_i && !expire_i |=> !flag_o);
  // R2: a started reset pulse lasts beyond its first cycle
  a_r2_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (RST_PULSE_CYC > 1) && $rose(rst_o) |=> rst_o);
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int MULT_W        = 5,
  parameter int RES_W         = 2,
  parameter int RST_PULSE_CYC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  wd_kick_i,
  input  logic                  cfg_wr_i,
  input  logic [MULT_W+RES_W:0] cfg_wdata_i,
  output logic [MULT_W+RES_W:0] cfg_rdata_o,
  input  logic                  flag_rd_i,
  output logic                  wd_flag_o,
  output logic                  wd_irq_o,
  output logic                  wd_rst_o
);
  logic              kick_edge, restart, expire, steer;
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;

  wdog_kick_edge u_edge (
    .clk(clk), .rst_n(rst_n), .kick_i(wd_kick_i), .edge_o(kick_edge)
  );

  assign restart = kick_edge | cfg_wr_i;

  wdog_cfg_reg #(.MULT_W(MULT_W), .RES_W(RES_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .wdata_i(cfg_wdata_i),
    .clr_i(expire && steer), .rdata_o(cfg_rdata_o),
    .steer_o(steer), .mult_o(mult), .res_o(res)
  );

  wdog_counter #(.MULT_W(MULT_W), .RES_W(RES_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .restart_i(restart),
    .mult_i(mult), .res_i(res), .expire_o(expire)
  );

  wdog_outputs #(.RST_PULSE_CYC(RST_PULSE_CYC)) u_out (
    .clk(clk), .rst_n(rst_n), .expire_i(expire), .steer_i(steer),
    .flag_rd_i(flag_rd_i), .flag_o(wd_flag_o), .irq_o(wd_irq_o),
    .rst_o(wd_rst_o)
  );

  // R2: a reset pulse starts together with the wiped configuration
  a_r2_cfg_wiped: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_o) |-> cfg_rdata_o == '0);
  // R4: a zero multiplier never expires
  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mult == '0) |-> !expire);
  // R5: a service edge pre-empts expiry in the same cycle
  a_r5_kick_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    kick_edge |-> !expire);
endmodule

// File: tb/test_wdog_steer.sv
module test_wdog_steer;
  localparam int PULSE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, kick = 1'b0, cfg_wr = 1'b0, flag_rd = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       wd_flag, wd_irq, wd_rst;

  always #5 clk = ~clk;

  wdog_steer #(.RST_PULSE_CYC(PULSE)) i_wdog_steer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wd_kick_i(kick),
    .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .flag_rd_i(flag_rd), .wd_flag_o(wd_flag), .wd_irq_o(wd_irq),
    .wd_rst_o(wd_rst)
  );

  typedef struct { bit steer; int ticks; string tag; } exp_t;
  exp_t q[$];
  exp_t cur;
  int   checks = 0, fails = 0, ticks_sent = 0;
  int   rst_len = 0, rst_pulses = 0;
  bit   flag_prev = 1'b0, rst_prev = 1'b0, finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ref_ticks(input int m, input int r);
    int step;
    case (r)
      0: step = 1;
      1: step = 4;
      2: step = 16;
      default: step = 64;
    endcase
    return m * step;
  endfunction

  // monitor: pops the scoreboard when the flag rises
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (wd_flag && !flag_prev) begin
        if (q.size() == 0) chk(1'b0, "R7 unexpected expiry", 1, 0);
        else begin
          cur = q.pop_front();
          chk(ticks_sent == cur.ticks, cur.tag, ticks_sent, cur.ticks);
          if (cur.steer) chk(wd_rst && !wd_irq, "R2 routed to reset", {wd_rst, wd_irq}, 2);
          else           chk(wd_irq && !wd_rst, "R3 routed to interrupt", {wd_rst, wd_irq}, 1);
        end
      end
      if (wd_rst) rst_len++;
      if (rst_prev && !wd_rst) begin
        rst_pulses++;
        chk(rst_len == PULSE, "R2 pulse width", rst_len, PULSE);
        rst_len = 0;
      end
      flag_prev = wd_flag;
      rst_prev  = wd_rst;
    end
  end

  task automatic write_cfg(input bit s, input int m, input int r);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = {s, 5'(m), 2'(r)}; ticks_sent = 0;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic send_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1; ticks_sent++;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic push(input bit s, input int t, input string tag);
    exp_t e;
    e.steer = s; e.ticks = t; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic run_irq(input int m, input int r);
    int t;
    t = ref_ticks(m, r);
    clear_flag();
    write_cfg(1'b0, m, r);
    push(1'b0, t, "R1 timeout ticks");
    send_ticks(t - 1);
    chk(wd_flag == 1'b0, "R1 no early expiry", wd_flag, 0);
    send_ticks(1);
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R1 expiry seen", q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R8 reset state
    chk(wd_flag == 1'b0, "R8 flag after reset", wd_flag, 0);
    chk(wd_irq == 1'b0, "R8 irq after reset", wd_irq, 0);
    chk(wd_rst == 1'b0, "R8 reset out after reset", wd_rst, 0);
    chk(cfg_rdata == 8'h00, "R8 config after reset", cfg_rdata, 0);

    // R9 read-back: {0, 00011, 01} = 0x0D
    write_cfg(1'b0, 3, 1);
    @(negedge clk);
    chk(cfg_rdata == 8'h0D, "R9 read-back", cfg_rdata, 8'h0D);

    // R1 each resolution code, plus the longest timeout
    run_irq(3, 0);
    run_irq(2, 1);
    run_irq(1, 2);
    run_irq(1, 3);
    run_irq(31, 3);

    // R3 interrupt held, then cleared by the flag read
    repeat (5) @(negedge clk);
    chk(wd_irq == 1'b1, "R3 irq held", wd_irq, 1);
    clear_flag();
    chk(wd_irq == 1'b0, "R3 irq cleared", wd_irq, 0);
    chk(wd_flag == 1'b0, "R3 flag cleared", wd_flag, 0);

    // R2 reset steering
    write_cfg(1'b1, 2, 0);
    push(1'b1, 2, "R2 timeout ticks");
    send_ticks(2);
    repeat (PULSE + 4) @(negedge clk);
    chk(cfg_rdata == 8'h00, "R2 config wiped", cfg_rdata, 0);
    chk(wd_rst == 1'b0, "R2 pulse ended", wd_rst, 0);
    chk(wd_irq == 1'b0, "R2 no interrupt", wd_irq, 0);
    chk(rst_pulses == 1, "R2 one pulse", rst_pulses, 1);
    send_ticks(20);
    chk(rst_pulses == 1, "R2 disarmed after wipe", rst_pulses, 1);

    // R4 zero multiplier
    clear_flag();
    write_cfg(1'b0, 0, 3);
    send_ticks(300);
    chk(wd_flag == 1'b0, "R4 disabled", wd_flag, 0);

    // R5 rising service edge restarts
    write_cfg(1'b0, 2, 1);
    send_ticks(6);
    @(negedge clk); kick = 1'b1; ticks_sent = 0;
    push(1'b0, 8, "R5 rising edge restart");
    send_ticks(8);
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R5 rising edge expiry seen", q.size(), 0);

    // R5 falling edge restarts
    clear_flag();
    write_cfg(1'b0, 1, 1);
    send_ticks(3);
    @(negedge clk); kick = 1'b0; ticks_sent = 0;
    push(1'b0, 4, "R5 falling edge restart");
    send_ticks(4);

    // R5 edge on the final tick blocks expiry
    clear_flag();
    write_cfg(1'b0, 1, 1);
    send_ticks(3);
    @(negedge clk); tick = 1'b1; kick = 1'b1; ticks_sent = 0;
    @(negedge clk); tick = 1'b0;
    chk(wd_flag == 1'b0, "R5 edge on final tick", wd_flag, 0);
    push(1'b0, 4, "R5 after blocked tick");
    send_ticks(4);

    // R6 write restarts
    clear_flag();
    write_cfg(1'b0, 2, 1);
    send_ticks(6);
    write_cfg(1'b0, 2, 1);
    push(1'b0, 8, "R6 write restart");
    send_ticks(8);

    // R7 expiry coinciding with a flag read
    clear_flag();
    write_cfg(1'b0, 1, 1);
    push(1'b0, 4, "R7 expiry with read");
    send_ticks(3);
    @(negedge clk); tick = 1'b1; flag_rd = 1'b1; ticks_sent++;
    @(negedge clk); tick = 1'b0; flag_rd = 1'b0;
    chk(wd_flag == 1'b1, "R7 flag survives read", wd_flag, 1);
    chk(wd_irq == 1'b1, "R7 irq survives read", wd_irq, 1);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R1 all expiries seen", q.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule